// File: doc/BRIEF.md
# Dual-Depth UART FIFO Trigger Controller

This block holds the transmit and receive byte queues of a serial port and raises one trigger output for each direction. The transmit trigger asks the host for more data. The receive trigger asks the host to drain the queue. Writes to a small register bank choose between two operating modes while the block runs.

In the compact mode both queues hold 32 bytes, and each trigger level comes from a 2-bit code in the control register. In the wide mode both queues hold 128 bytes, and each level is programmed directly as a byte value. The wide mode is active whenever any of four extra byte registers holds a nonzero value. Any change to the queue size flushes both queues.

Register addresses:
- 0: control register. Bit 0 enables the queues, bits 5:4 hold the transmit code, bits 7:6 hold the receive code.
- 1: feature register. Bit 0 unlocks the transmit code.
- 2: transmit level.
- 3: receive level.
- 4: flow-high.
- 5: flow-low.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset both counts are 0, both overrun flags are 0, `ext_mode` is 0, the control and extra registers are zero, and `tx_trig` is 1 while `rx_trig` is 0.
- R2: `ext_mode` is 1 exactly when at least one of registers 2, 3, 4 or 5 is nonzero.
- R3: The queue capacity is 32 entries when `ext_mode` is 0 and 128 entries when it is 1. A push to a full queue stores nothing, leaves the count unchanged and sets that queue's sticky overrun flag.
- R4: When `ext_mode` is 0, control bits 7:6 set the receive level: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 28. `rx_trig` is 1 while `rx_count` is at least that level.
- R5: When `ext_mode` is 0, the active transmit code sets the transmit level: 00 gives 16, 01 gives 8, 10 gives 24 and 11 gives 30. `tx_trig` is 1 while the number of free transmit slots (capacity minus `tx_count`) is at least that level.
- R6: The active transmit code equals control bits 5:4 only while feature register bit 0 is 1. Otherwise the code is 00 (level 16), whatever bits 5:4 hold.
- R7: When `ext_mode` is 1, register 2 sets the transmit level and register 3 sets the receive level. A value of 0 acts as 1, and values above 128 act as 128.
- R8: A register write flushes both queues at its clock edge in either of two cases: it toggles control bit 0, or it changes `ext_mode`. A flush zeroes both counts and both overrun flags and discards all stored data. A write that does neither keeps the stored data.
- R9: Pops return bytes in push order. The popped byte appears on the data output after the clock edge of the pop.
- R10: A pop from an empty queue leaves the data output holding the last popped byte, and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tx_push | input | 1 | Transmit queue push strobe |
| tx_din | input | 8 | Transmit push data |
| tx_pop | input | 1 | Transmit queue pop strobe |
| tx_dout | output | 8 | Last popped transmit byte |
| rx_push | input | 1 | Receive queue push strobe |
| rx_din | input | 8 | Receive push data |
| rx_pop | input | 1 | Receive queue pop strobe |
| rx_dout | output | 8 | Last popped receive byte |
| tx_count | output | 8 | Transmit queue fill count |
| rx_count | output | 8 | Receive queue fill count |
| tx_trig | output | 1 | Transmit trigger (enough free slots) |
| rx_trig | output | 1 | Receive trigger (enough stored bytes) |
| tx_ovr | output | 1 | Transmit overrun flag |
| rx_ovr | output | 1 | Receive overrun flag |
| ext_mode | output | 1 | 1 when the 128-entry mode is active |

## Verification
A wrong capacity shows as a count that stops at the wrong value, or as an overrun flag that sets too early or too late. A wrong level table shows as a trigger that switches one push away from the expected boundary. Both appear in the cycle after the offending push or write, because the triggers are combinational on registered counts and registers. A missed or spurious flush shows on the counts in the cycle after the register write. Pointer or storage faults show up later, as a data mismatch on the first pop that reaches the damaged entry.

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl #(
  parameter int DATA_W    = 8,
  parameter int DEPTH_LEG = 32,
  parameter int DEPTH_EXT = 128,
  localparam int CW = $clog2(DEPTH_EXT + 1),
  localparam int PW = $clog2(DEPTH_EXT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_dout,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_din,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_dout,
  output logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_count,
  output logic              tx_trig,
  output logic              rx_trig,
  output logic              tx_ovr,
  output logic              rx_ovr,
  output logic              ext_mode
);

  logic [7:0] ctl_q, ctl_d;
  logic       enh_q;
  logic [7:0] lvl_q [4];
  logic [7:0] lvl_d [4];
  logic       ext_d, flush;

  always_comb begin
    ctl_d = (wr_en && wr_addr == 3'd0) ? wr_data : ctl_q;
    for (int i = 0; i < 4; i++)
      lvl_d[i] = (wr_en && wr_addr == 3'(i + 2)) ? wr_data : lvl_q[i];
  end

  assign ext_mode = |{lvl_q[0], lvl_q[1], lvl_q[2], lvl_q[3]};
  assign ext_d    = |{lvl_d[0], lvl_d[1], lvl_d[2], lvl_d[3]};
  assign flush    = (ctl_d[0] ^ ctl_q[0]) | (ext_d ^ ext_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      enh_q <= 1'b0;
      for (int i = 0; i < 4; i++) lvl_q[i] <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (wr_en && wr_addr == 3'd1) enh_q <= wr_data[0];
      for (int i = 0; i < 4; i++) lvl_q[i] <= lvl_d[i];
    end
  end

  function automatic logic [CW-1:0] clamp_lvl(input logic [7:0] v);
    if (v == 8'd0) return CW'(1);
    if (CW'(v) > CW'(DEPTH_EXT)) return CW'(DEPTH_EXT);
    return CW'(v);
  endfunction

  logic [CW-1:0] depth, rx_lvl, tx_lvl;
  logic [1:0]    tx_code;

  assign depth   = ext_mode ? CW'(DEPTH_EXT) : CW'(DEPTH_LEG);
  assign tx_code = enh_q ? ctl_q[5:4] : 2'b00;

  always_comb begin
    if (ext_mode) begin
      rx_lvl = clamp_lvl(lvl_q[1]);
      tx_lvl = clamp_lvl(lvl_q[0]);
    end else begin
      case (ctl_q[7:6])
        2'b00:   rx_lvl = CW'(8);
        2'b01:   rx_lvl = CW'(16);
        2'b10:   rx_lvl = CW'(24);
        default: rx_lvl = CW'(28);
      endcase
      case (tx_code)
        2'b00:   tx_lvl = CW'(16);
        2'b01:   tx_lvl = CW'(8);
        2'b10:   tx_lvl = CW'(24);
        default: tx_lvl = CW'(30);
      endcase
    end
  end

  logic [1:0]        push_v, pop_v;
  logic [DATA_W-1:0] din_v [2];
  assign push_v   = {rx_push, tx_push};
  assign pop_v    = {rx_pop, tx_pop};
  assign din_v[0] = tx_din;
  assign din_v[1] = rx_din;

  for (genvar g = 0; g < 2; g++) begin : ch
    logic [DATA_W-1:0] mem [DEPTH_EXT];
    logic [CW-1:0]     cnt;
    logic [PW-1:0]     wp, rp;
    logic [DATA_W-1:0] q;
    logic              ovr;
    logic              acc_push, acc_pop;

    assign acc_push = push_v[g] && (cnt < depth);
    assign acc_pop  = pop_v[g] && (cnt != '0);

    always_ff @(posedge clk)
      if (acc_push && !flush) mem[wp] <= din_v[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0; wp <= '0; rp <= '0; q <= '0; ovr <= 1'b0;
      end else if (flush) begin
        cnt <= '0; wp <= '0; rp <= '0; ovr <= 1'b0;
      end else begin
        if (acc_push) wp <= (wp == PW'(DEPTH_EXT - 1)) ? '0 : wp + 1'b1;
        if (push_v[g] && !acc_push) ovr <= 1'b1;
        if (acc_pop) begin
          q  <= mem[rp];
          rp <= (rp == PW'(DEPTH_EXT - 1)) ? '0 : rp + 1'b1;
        end
        cnt <= cnt + CW'(acc_push) - CW'(acc_pop);
      end
    end
  end

  assign tx_count = ch[0].cnt;
  assign rx_count = ch[1].cnt;
  assign tx_dout  = ch[0].q;
  assign rx_dout  = ch[1].q;
  assign tx_ovr   = ch[0].ovr;
  assign rx_ovr   = ch[1].ovr;
  assign tx_trig  = (depth - ch[0].cnt) >= tx_lvl;
  assign rx_trig  = ch[1].cnt >= rx_lvl;

endmodule

module fifo_trig_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int DEPTH_LEG = 32,
  parameter int DEPTH_EXT = 128,
  localparam int CW = $clog2(DEPTH_EXT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [DATA_W-1:0] rx_dout,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_trig,
  input logic              rx_trig,
  input logic              rx_ovr,
  input logic              ext_mode
);
  logic [CW-1:0] lim;
  assign lim = ext_mode ? CW'(DEPTH_EXT) : CW'(DEPTH_LEG);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= lim && rx_count <= lim);

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_count == lim && !wr_en |=> rx_ovr && $stable(rx_count));

  assert_mode_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_mode) |-> tx_count == '0 && rx_count == '0 && !rx_ovr);

  assert_rx_trig_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> rx_count != '0);

  assert_tx_trig_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count == '0 |-> tx_trig);

  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && !rx_push && !wr_en && rx_count == '0 |=> $stable(rx_dout) && rx_count == '0);
endmodule

bind fifo_trig_ctrl fifo_trig_ctrl_chk #(
  .DATA_W(DATA_W), .DEPTH_LEG(DEPTH_LEG), .DEPTH_EXT(DEPTH_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_dout(rx_dout), .tx_count(tx_count), .rx_count(rx_count), .tx_trig(tx_trig),
  .rx_trig(rx_trig), .rx_ovr(rx_ovr), .ext_mode(ext_mode)
);

// File: tb/fifo_trig_ctrl_tb.sv
module fifo_trig_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout, tx_count, rx_count;
  logic tx_trig, rx_trig, tx_ovr, rx_ovr, ext_mode;

  always #5 clk = ~clk;

  fifo_trig_ctrl u_dut (.*);

  int n_run = 0, n_fail = 0;
  int mdepth = 32;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic pend_tx = 1'b0, pend_rx = 1'b0;

  task automatic chk(input string r, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    pend_tx <= tx_pop && txq.size() > 0;
    pend_rx <= rx_pop && rxq.size() > 0;
  end

  always @(negedge clk) begin
    if (pend_tx) chk("R9 tx order", int'(tx_dout), int'(txq.pop_front()));
    if (pend_rx) chk("R9 rx order", int'(rx_dout), int'(rxq.pop_front()));
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flush_model(input int dep);
    txq.delete(); rxq.delete(); mdepth = dep;
  endtask

  task automatic push(input int ch, input logic [7:0] d);
    if (ch == 0) begin
      tx_push = 1'b1; tx_din = d;
      if (txq.size() < mdepth) txq.push_back(d);
    end else begin
      rx_push = 1'b1; rx_din = d;
      if (rxq.size() < mdepth) rxq.push_back(d);
    end
    @(negedge clk);
    tx_push = 1'b0; rx_push = 1'b0;
  endtask

  task automatic pop(input int ch);
    if (ch == 0) tx_pop = 1'b1; else rx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0; rx_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_trig", tx_trig, 1);
    chk("R1 rx_trig", rx_trig, 0);
    chk("R1 ext_mode", ext_mode, 0);
    chk("R1 ovr", {30'd0, tx_ovr, rx_ovr}, 0);

    wr(3'd0, 8'h01); flush_model(32);
    for (int i = 0; i < 7; i++) push(1, 8'(i * 3 + 1));
    chk("R4 rx below 8", rx_trig, 0);
    push(1, 8'hA5);
    chk("R4 rx at 8", rx_trig, 1);
    wr(3'd0, 8'hC1);
    chk("R4 code 11 level 28", rx_trig, 0);
    chk("R8 no flush on same size", rx_count, 8);
    for (int i = 0; i < 3; i++) pop(1);
    for (int i = 0; i < 23; i++) push(1, 8'(i + 40));
    chk("R4 rx at 28", rx_trig, 1);
    for (int i = 0; i < 4; i++) push(1, 8'(i + 90));
    chk("R3 full 32", rx_count, 32);
    chk("R3 no ovr yet", rx_ovr, 0);
    push(1, 8'hEE);
    chk("R3 ovr set", rx_ovr, 1);
    chk("R3 count held", rx_count, 32);
    for (int i = 0; i < 32; i++) pop(1);
    @(negedge clk);
    held = rx_dout;
    pop(1);
    @(negedge clk);
    chk("R10 dout held", rx_dout, held);
    chk("R10 count 0", rx_count, 0);

    wr(3'd0, 8'h11);
    for (int i = 0; i < 17; i++) push(0, 8'(i + 7));
    chk("R6 code locked at 16", tx_trig, 0);
    wr(3'd1, 8'h01);
    chk("R6 code 01 level 8", tx_trig, 1);
    wr(3'd0, 8'h31);
    chk("R5 code 11 level 30", tx_trig, 0);
    for (int i = 0; i < 14; i++) pop(0);
    chk("R5 free 29", tx_trig, 0);
    pop(0);
    chk("R5 free 30", tx_trig, 1);

    push(1, 8'h11); push(1, 8'h22);
    wr(3'd0, 8'h30); flush_model(32);
    chk("R8 enable flush tx", tx_count, 0);
    chk("R8 enable flush rx", rx_count, 0);
    chk("R8 ovr cleared", rx_ovr, 0);
    wr(3'd0, 8'h01); flush_model(32);

    push(1, 8'h33);
    wr(3'd4, 8'h05); flush_model(128);
    chk("R2 ext on", ext_mode, 1);
    chk("R8 mode flush", rx_count, 0);
    chk("R7 level 0 acts as 1 empty", rx_trig, 0);
    push(1, 8'h44);
    chk("R7 level 0 acts as 1", rx_trig, 1);
    wr(3'd3, 8'd200);
    chk("R7 clamp 128 below", rx_trig, 0);
    for (int i = 0; i < 126; i++) push(1, 8'(i * 5));
    chk("R7 count 127", rx_trig, 0);
    push(1, 8'h77);
    chk("R7 at 128", rx_trig, 1);
    push(1, 8'h78);
    chk("R3 ext depth 128", rx_count, 128);
    chk("R3 ext ovr", rx_ovr, 1);
    wr(3'd2, 8'd100);
    for (int i = 0; i < 29; i++) push(0, 8'(i + 200));
    chk("R7 tx free 99", tx_trig, 0);
    pop(0);
    chk("R7 tx free 100", tx_trig, 1);
    for (int i = 0; i < 5; i++) pop(1);

    wr(3'd4, 8'h00);
    chk("R2 still ext", ext_mode, 1);
    chk("R8 data kept", rx_count, 123);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00); flush_model(32);
    chk("R2 ext off", ext_mode, 0);
    chk("R8 exit flush", rx_count + tx_count, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule